// File: doc/BRIEF.md
# Shared Packet Buffer Allocator

This block manages one packet memory that the transmit and receive directions share. The memory is split into fixed pages and there is no fixed boundary between the directions. Each packet gets the number of pages its byte count needs. The pages are taken from a free-page bitmap and need not be adjacent. The packet is then identified by a packet number. Pages go back to the pool when the host releases the packet. When auto-release is on, they also go back when the MAC reports that the packet has finished transmitting.

Three requesters share one command engine, and each uses a valid/ready handshake:

- **Host command port.** Carries an opcode, a byte count and a packet number.
- **Receive request port.** The MAC uses it to ask for a buffer when a frame arrives.
- **Transmit-completion port.** The MAC uses it each time it finishes sending the packet at the head of the transmit queue.

A requester that holds valid while its ready is low is not served, and nothing is latched from it. It may keep valid high until ready rises. The engine accepts one request, executes it on the next edge and then returns to idle.

A host-written receive reserve keeps a number of pages that receive traffic cannot take, so that incoming frames cannot starve transmit allocation. The block also keeps two queues of packet numbers:

- a transmit queue, whose head is shown to the MAC;
- a transmit-done queue, whose head is shown to the host.

Top module: `shared_buf_alloc`

## Requirements
- R1: After reset all NUM_PAGES pages are free, both queues are empty, `cmd_ready` is high and neither done output is asserted.
- R2: A request is accepted on an edge where valid and ready are both high. For a host command, `resp_done` is high for exactly one cycle, in the cycle after the following edge. All three ready outputs are low in the cycle after acceptance. A host command held while `cmd_ready` is low is not executed.
- R3: A host allocation (opcode 1) takes ceil(bytes/PAGE_BYTES) pages and returns the lowest unused packet number on `resp_pkt`. A byte count of zero, or one needing more pages than are free, sets `resp_fail` and consumes no pages.
- R4: A receive allocation succeeds only when free pages minus needed pages stays at or above `rx_reserve`. Otherwise `rx_fail` is set and no pages are consumed. Host allocations ignore the reserve.
- R5: Release (opcode 3) returns the pages of packet `cmd_pkt` to the pool. If that packet is at the head of the done queue, it is also removed from that queue. Releasing a packet that is not allocated sets `resp_fail` and changes nothing.
- R6: Enqueue (opcode 4) appends an allocated `cmd_pkt` to the tail of the transmit queue, and `tx_head_pkt` shows the oldest entry. Enqueue fails if the packet is not allocated, or if the two queues together already hold NUM_PAGES entries.
- R7: A transmit completion pops the head of the transmit queue. With `auto_release` low the number moves to the tail of the done queue. With `auto_release` high the packet's pages are freed and the done queue is not touched. A completion with an empty transmit queue has no effect.
- R8: Reset-allocator (opcode 2) frees every page, forgets every packet and empties both queues.
- R9: Reset-transmit-queue (opcode 5) empties both queues and leaves all allocations and the free page count unchanged.
- R10: When several requesters are valid at an idle engine, the host is served first, then receive, then transmit completion. A ready output is high only for the requester that would be served.
- R11: An allocation takes the lowest-numbered free pages. It succeeds whenever enough pages are free in total, however fragmented they are.
- R12: No operation (opcode 0) and the unassigned opcodes 6 and 7 complete with `resp_done` high, `resp_fail` low and no change of state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host command present |
| cmd_ready | output | 1 | Engine will take the host command |
| cmd_op | input | 3 | Opcode (0 nop, 1 alloc, 2 reset allocator, 3 release, 4 enqueue, 5 reset transmit queue) |
| cmd_bytes | input | BW (14) | Byte count for an allocation |
| cmd_pkt | input | PGW (5) | Packet number for release or enqueue |
| resp_done | output | 1 | One-cycle completion pulse for a host command |
| resp_fail | output | 1 | Command failed; valid with `resp_done` |
| resp_pkt | output | PGW (5) | Allocated packet number; valid with a successful allocation |
| rx_valid | input | 1 | Receive buffer request present |
| rx_ready | output | 1 | Engine will take the receive request |
| rx_bytes | input | BW (14) | Receive frame byte count |
| rx_done | output | 1 | One-cycle completion pulse for a receive request |
| rx_fail | output | 1 | Receive allocation refused |
| rx_pkt | output | PGW (5) | Packet number given to the receive frame |
| rx_reserve | input | CW (6) | Pages that receive allocations must leave free |
| auto_release | input | 1 | Free packet pages on transmit completion |
| txc_valid | input | 1 | Transmit of queue head completed |
| txc_ready | output | 1 | Engine will take the completion |
| tx_head_valid | output | 1 | Transmit queue not empty |
| tx_head_pkt | output | PGW (5) | Oldest packet in the transmit queue |
| done_head_valid | output | 1 | Done queue not empty |
| done_head_pkt | output | PGW (5) | Oldest packet in the done queue |
| free_pages | output | CW (6) | Number of free pages |

## Verification
The assertions check the following on every cycle:
- the one-cycle done pulse and that ready drops after acceptance;
- that a failed allocation leaves the free count untouched;
- that a successful receive allocation never dips below the reserve;
- that every allocation draws only free pages, in the exact number needed;
- that a reset of either kind empties what it should;
- that the queues never overflow or underflow.

The bench's scenarios are needed to show the rest, because only a running reference model can tell which packet number and pages are correct:
- lowest-page choice with a fragmented pool;
- order and content of the two queues;
- auto-release against hand-back through the done queue;
- that a command held during busy is not executed;
- request priority when all three requesters collide.

// File: rtl/sba_pkg.sv
package sba_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RELEASE = 3'd3,
    OP_ENQ     = 3'd4,
    OP_TXQ_RST = 3'd5
  } sba_op_e;

  typedef enum logic [1:0] {
    SRC_HOST = 2'd0,
    SRC_RX   = 2'd1,
    SRC_TXC  = 2'd2
  } sba_src_e;

endpackage

// File: rtl/sba_page_pick.sv
// Chooses the lowest-numbered free pages, as many as requested.
module sba_page_pick #(
  parameter int N  = 32,
  parameter int NW = 15
) (
  input  logic [N-1:0]  free_map,
  input  logic [NW-1:0] need,
  output logic [N-1:0]  sel,
  output logic          enough
);

  logic [NW-1:0] taken;

  always_comb begin
    logic [NW-1:0] run;
    run = '0;
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (free_map[i] && (run < need)) begin
        sel[i] = 1'b1;
        run    = run + 1'b1;
      end
    end
    taken = run;
  end

  assign enough = (taken == need);

endmodule

// File: rtl/sba_queue.sv
// Circular queue of packet numbers with synchronous clear.
module sba_queue #(
  parameter int DEPTH = 32,
  parameter int W     = 5,
  localparam int AW   = $clog2(DEPTH),
  localparam int CNTW = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            push,
  input  logic [W-1:0]    din,
  input  logic            pop,
  output logic [W-1:0]    head,
  output logic            empty,
  output logic            full,
  output logic [CNTW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == CNTW'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clear) |-> !full);

  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !clear) |-> !empty);

endmodule

// File: rtl/sba_arbiter.sv
// Fixed-priority choice among host, receive and completion requests.
module sba_arbiter (
  input  logic busy,
  input  logic cmd_valid,
  input  logic rx_valid,
  input  logic txc_valid,
  output logic cmd_ready,
  output logic rx_ready,
  output logic txc_ready,
  output logic take_host,
  output logic take_rx,
  output logic take_txc
);

  assign cmd_ready = !busy;
  assign rx_ready  = !busy && !cmd_valid;
  assign txc_ready = !busy && !cmd_valid && !rx_valid;

  assign take_host = cmd_valid && cmd_ready;
  assign take_rx   = rx_valid  && rx_ready;
  assign take_txc  = txc_valid && txc_ready;

endmodule

// File: rtl/shared_buf_alloc.sv
module shared_buf_alloc
  import sba_pkg::*;
#(
  parameter int NUM_PAGES  = 32,
  parameter int PAGE_BYTES = 256,
  localparam int PGW = $clog2(NUM_PAGES),
  localparam int CW  = PGW + 1,
  localparam int BW  = $clog2(NUM_PAGES * PAGE_BYTES) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [BW-1:0]  cmd_bytes,
  input  logic [PGW-1:0] cmd_pkt,
  output logic           resp_done,
  output logic           resp_fail,
  output logic [PGW-1:0] resp_pkt,
  input  logic           rx_valid,
  output logic           rx_ready,
  input  logic [BW-1:0]  rx_bytes,
  output logic           rx_done,
  output logic           rx_fail,
  output logic [PGW-1:0] rx_pkt,
  input  logic [CW-1:0]  rx_reserve,
  input  logic           auto_release,
  input  logic           txc_valid,
  output logic           txc_ready,
  output logic           tx_head_valid,
  output logic [PGW-1:0] tx_head_pkt,
  output logic           done_head_valid,
  output logic [PGW-1:0] done_head_pkt,
  output logic [CW-1:0]  free_pages
);

  localparam int PSH = $clog2(PAGE_BYTES);
  localparam int NW  = BW + 1;

  // Engine state
  logic           busy;
  sba_src_e       lat_src;
  logic [2:0]     lat_op;
  logic [BW-1:0]  lat_bytes;
  logic [PGW-1:0] lat_pkt;

  // Page and packet bookkeeping
  logic [NUM_PAGES-1:0] free_map;
  logic [NUM_PAGES-1:0] pkt_live;
  logic [NUM_PAGES-1:0] pkt_mask [NUM_PAGES];

  logic take_host, take_rx, take_txc;

  sba_arbiter u_arb (
    .busy      (busy),
    .cmd_valid (cmd_valid),
    .rx_valid  (rx_valid),
    .txc_valid (txc_valid),
    .cmd_ready (cmd_ready),
    .rx_ready  (rx_ready),
    .txc_ready (txc_ready),
    .take_host (take_host),
    .take_rx   (take_rx),
    .take_txc  (take_txc)
  );

  // Size of the latched request in pages
  logic [NW-1:0] need_wide;
  logic          size_ok;
  assign need_wide = ({1'b0, lat_bytes} + NW'(PAGE_BYTES - 1)) >> PSH;
  assign size_ok   = (lat_bytes != '0) && (need_wide <= NW'(NUM_PAGES));

  logic [NUM_PAGES-1:0] sel;
  logic                 enough;

  sba_page_pick #(.N(NUM_PAGES), .NW(NW)) u_pick (
    .free_map (free_map),
    .need     (need_wide),
    .sel      (sel),
    .enough   (enough)
  );

  logic [CW-1:0] free_cnt;
  assign free_cnt   = CW'($countones(free_map));
  assign free_pages = free_cnt;

  // Lowest unused packet number
  logic [PGW-1:0] slot;
  always_comb begin
    slot = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!pkt_live[i]) slot = PGW'(i);
    end
  end

  // Queues
  logic           txq_push, txq_pop, txq_clear, txq_empty, txq_full;
  logic           dq_push, dq_pop, dq_empty, dq_full;
  logic [PGW-1:0] txq_head, dq_head;
  logic [CW-1:0]  txq_count, dq_count;

  // Decode of the request being executed
  logic is_host, is_alloc, alloc_ok, rx_room;
  logic do_rel, rel_ok, do_enq, enq_ok, do_txc, txc_has, do_rst, do_txq_rst;
  logic auto_free;

  assign is_host    = busy && (lat_src == SRC_HOST);
  assign is_alloc   = (is_host && (lat_op == OP_ALLOC)) || (busy && (lat_src == SRC_RX));
  assign rx_room    = (NW+1)'(free_cnt) >= (NW+1)'(need_wide) + (NW+1)'(rx_reserve);
  assign alloc_ok   = size_ok && enough && ((lat_src != SRC_RX) || rx_room);
  assign do_rel     = is_host && (lat_op == OP_RELEASE);
  assign rel_ok     = pkt_live[lat_pkt];
  assign do_enq     = is_host && (lat_op == OP_ENQ);
  assign enq_ok     = pkt_live[lat_pkt] &&
                      ((CW+1)'(txq_count) + (CW+1)'(dq_count) < (CW+1)'(NUM_PAGES));
  assign do_txc     = busy && (lat_src == SRC_TXC);
  assign txc_has    = !txq_empty;
  assign do_rst     = is_host && (lat_op == OP_RESET);
  assign do_txq_rst = is_host && (lat_op == OP_TXQ_RST);
  assign auto_free  = do_txc && txc_has && auto_release && pkt_live[txq_head];

  assign txq_clear = do_rst || do_txq_rst;
  assign txq_push  = do_enq && enq_ok;
  assign txq_pop   = do_txc && txc_has;
  assign dq_push   = do_txc && txc_has && !auto_release;
  assign dq_pop    = do_rel && rel_ok && !dq_empty && (dq_head == lat_pkt);

  sba_queue #(.DEPTH(NUM_PAGES), .W(PGW)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (txq_clear),
    .push  (txq_push),
    .din   (lat_pkt),
    .pop   (txq_pop),
    .head  (txq_head),
    .empty (txq_empty),
    .full  (txq_full),
    .count (txq_count)
  );

  sba_queue #(.DEPTH(NUM_PAGES), .W(PGW)) u_dq (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (txq_clear),
    .push  (dq_push),
    .din   (txq_head),
    .pop   (dq_pop),
    .head  (dq_head),
    .empty (dq_empty),
    .full  (dq_full),
    .count (dq_count)
  );

  assign tx_head_valid   = !txq_empty;
  assign tx_head_pkt     = txq_head;
  assign done_head_valid = !dq_empty;
  assign done_head_pkt   = dq_head;

  // Accept, then execute on the following edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      lat_src   <= SRC_HOST;
      lat_op    <= OP_NOP;
      lat_bytes <= '0;
      lat_pkt   <= '0;
      resp_done <= 1'b0;
      resp_fail <= 1'b0;
      resp_pkt  <= '0;
      rx_done   <= 1'b0;
      rx_fail   <= 1'b0;
      rx_pkt    <= '0;
      free_map  <= '1;
      pkt_live  <= '0;
      for (int i = 0; i < NUM_PAGES; i++) pkt_mask[i] <= '0;
    end else begin
      resp_done <= 1'b0;
      rx_done   <= 1'b0;
      if (!busy) begin
        busy <= take_host || take_rx || take_txc;
        if (take_host) begin
          lat_src   <= SRC_HOST;
          lat_op    <= cmd_op;
          lat_bytes <= cmd_bytes;
          lat_pkt   <= cmd_pkt;
        end else if (take_rx) begin
          lat_src   <= SRC_RX;
          lat_op    <= OP_ALLOC;
          lat_bytes <= rx_bytes;
        end else if (take_txc) begin
          lat_src   <= SRC_TXC;
        end
      end else begin
        busy <= 1'b0;
        if (is_alloc && alloc_ok) begin
          free_map       <= free_map & ~sel;
          pkt_live[slot] <= 1'b1;
          pkt_mask[slot] <= sel;
        end
        if (do_rel && rel_ok) begin
          free_map          <= free_map | pkt_mask[lat_pkt];
          pkt_live[lat_pkt] <= 1'b0;
          pkt_mask[lat_pkt] <= '0;
        end
        if (auto_free) begin
          free_map           <= free_map | pkt_mask[txq_head];
          pkt_live[txq_head] <= 1'b0;
          pkt_mask[txq_head] <= '0;
        end
        if (do_rst) begin
          free_map <= '1;
          pkt_live <= '0;
          for (int i = 0; i < NUM_PAGES; i++) pkt_mask[i] <= '0;
        end
        if (lat_src == SRC_HOST) begin
          resp_done <= 1'b1;
          resp_pkt  <= (is_alloc && alloc_ok) ? slot : '0;
          case (lat_op)
            OP_ALLOC:   resp_fail <= !alloc_ok;
            OP_RELEASE: resp_fail <= !rel_ok;
            OP_ENQ:     resp_fail <= !enq_ok;
            default:    resp_fail <= 1'b0;
          endcase
        end else if (lat_src == SRC_RX) begin
          rx_done <= 1'b1;
          rx_fail <= !alloc_ok;
          rx_pkt  <= alloc_ok ? slot : '0;
        end
      end
    end
  end

  // Checks beside the engine
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_done |=> !resp_done);

  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && !rx_ready && !txc_ready));

  assert_fail_no_pages_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((resp_done && resp_fail) || (rx_done && rx_fail)) |-> (free_pages == $past(free_pages)));

  assert_reserve_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_fail) |-> (free_pages >= $past(rx_reserve)));

  assert_alloc_from_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_alloc && alloc_ok) |-> (((sel & ~free_map) == '0) && ($countones(sel) == int'(need_wide))));

  assert_reset_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> (free_pages == CW'(NUM_PAGES)));

  assert_queues_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    txq_clear |=> (!tx_head_valid && !done_head_valid));

endmodule

// File: tb/shared_buf_alloc_bench.sv
module shared_buf_alloc_bench;

  localparam int NP = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [13:0] cmd_bytes = '0;
  logic [4:0]  cmd_pkt = '0;
  logic        resp_done, resp_fail;
  logic [4:0]  resp_pkt;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [13:0] rx_bytes = '0;
  logic        rx_done, rx_fail;
  logic [4:0]  rx_pkt;
  logic [5:0]  rx_reserve = '0;
  logic        auto_release = 1'b0;
  logic        txc_valid = 1'b0;
  logic        txc_ready;
  logic        tx_head_valid, done_head_valid;
  logic [4:0]  tx_head_pkt, done_head_pkt;
  logic [5:0]  free_pages;

  shared_buf_alloc u_shared_buf_alloc (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_bytes(cmd_bytes), .cmd_pkt(cmd_pkt),
    .resp_done(resp_done), .resp_fail(resp_fail), .resp_pkt(resp_pkt),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_bytes(rx_bytes),
    .rx_done(rx_done), .rx_fail(rx_fail), .rx_pkt(rx_pkt),
    .rx_reserve(rx_reserve), .auto_release(auto_release),
    .txc_valid(txc_valid), .txc_ready(txc_ready),
    .tx_head_valid(tx_head_valid), .tx_head_pkt(tx_head_pkt),
    .done_head_valid(done_head_valid), .done_head_pkt(done_head_pkt),
    .free_pages(free_pages)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;

  // Reference model
  logic [NP-1:0] m_free = '1;
  logic [NP-1:0] m_mask [NP];
  bit            m_live [NP];
  int            m_txq [$];
  int            m_dq [$];

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int f_need(input int b);
    return (b + 255) / 256;
  endfunction

  function automatic int f_cnt(input logic [NP-1:0] f);
    int c = 0;
    for (int i = 0; i < NP; i++) c += int'(f[i]);
    return c;
  endfunction

  function automatic logic [NP-1:0] f_pick(input logic [NP-1:0] f, input int need);
    logic [NP-1:0] s = '0;
    int c = 0;
    for (int i = 0; i < NP; i++) if (f[i] && c < need) begin s[i] = 1'b1; c++; end
    return s;
  endfunction

  function automatic int f_slot();
    for (int i = 0; i < NP; i++) if (!m_live[i]) return i;
    return 0;
  endfunction

  task automatic m_reset_all();
    m_free = '1;
    for (int i = 0; i < NP; i++) begin m_live[i] = 0; m_mask[i] = '0; end
    m_txq.delete();
    m_dq.delete();
  endtask

  task automatic m_free_pkt(input int p);
    m_free = m_free | m_mask[p];
    m_mask[p] = '0;
    m_live[p] = 0;
  endtask

  task automatic m_alloc(input int b, input int res, input bit is_rx,
                         output bit fail, output int pkt);
    int need = f_need(b);
    int cnt = f_cnt(m_free);
    pkt = 0;
    fail = (b == 0) || (need > cnt) || (is_rx && (cnt - need < res));
    if (!fail) begin
      pkt = f_slot();
      m_mask[pkt] = f_pick(m_free, need);
      m_free = m_free & ~m_mask[pkt];
      m_live[pkt] = 1;
    end
  endtask

  task automatic m_host(input int op, input int b, input int p, output bit fail, output int pkt);
    fail = 0;
    pkt = 0;
    case (op)
      1: m_alloc(b, 0, 0, fail, pkt);
      2: m_reset_all();
      3: begin
        fail = !m_live[p];
        if (!fail) begin
          m_free_pkt(p);
          if (m_dq.size() > 0 && m_dq[0] == p) void'(m_dq.pop_front());
        end
      end
      4: begin
        fail = !m_live[p] || (m_txq.size() + m_dq.size() >= NP);
        if (!fail) m_txq.push_back(p);
      end
      5: begin m_txq.delete(); m_dq.delete(); end
      default: ;
    endcase
  endtask

  task automatic m_txc();
    if (m_txq.size() > 0) begin
      int p = m_txq.pop_front();
      if (auto_release) begin
        if (m_live[p]) m_free_pkt(p);
      end else begin
        m_dq.push_back(p);
      end
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " free_pages"}, int'(free_pages), f_cnt(m_free));
    chk({tag, " tx_head_valid"}, int'(tx_head_valid), int'(m_txq.size() > 0));
    if (m_txq.size() > 0) chk({tag, " tx_head_pkt"}, int'(tx_head_pkt), m_txq[0]);
    chk({tag, " done_head_valid"}, int'(done_head_valid), int'(m_dq.size() > 0));
    if (m_dq.size() > 0) chk({tag, " done_head_pkt"}, int'(done_head_pkt), m_dq[0]);
  endtask

  // Host command: accept on first edge, execute on second, check after it.
  task automatic host_cmd(input int op, input int b, input int p, input string tag);
    bit efail;
    int epkt;
    @(negedge clk);
    cmd_op = 3'(op); cmd_bytes = 14'(b); cmd_pkt = 5'(p); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " R2 done early"}, int'(resp_done), 0);
    @(negedge clk);
    m_host(op, b, p, efail, epkt);
    chk({tag, " R2 done pulse"}, int'(resp_done), 1);
    chk({tag, " fail"}, int'(resp_fail), int'(efail));
    if (op == 1 && !efail) chk({tag, " pkt"}, int'(resp_pkt), epkt);
    check_state(tag);
  endtask

  task automatic rx_req(input int b, input int res, input string tag);
    bit efail;
    int epkt;
    @(negedge clk);
    rx_bytes = 14'(b); rx_reserve = 6'(res); rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
    m_alloc(b, res, 1, efail, epkt);
    chk({tag, " R4 rx_done"}, int'(rx_done), 1);
    chk({tag, " R4 rx_fail"}, int'(rx_fail), int'(efail));
    if (!efail) chk({tag, " R4 rx_pkt"}, int'(rx_pkt), epkt);
    check_state(tag);
  endtask

  task automatic txc_evt(input string tag);
    @(negedge clk);
    txc_valid = 1'b1;
    @(negedge clk);
    txc_valid = 1'b0;
    @(negedge clk);
    m_txc();
    check_state(tag);
  endtask

  function automatic int pick_live(input int start);
    for (int k = 0; k < NP; k++) if (m_live[(start + k) % NP]) return (start + k) % NP;
    return start % NP;
  endfunction

  function automatic int rnd_bytes();
    int r = int'($urandom % 10);
    if (r == 0) return 0;
    if (r == 1) return 9000;
    return 1 + int'($urandom % 2000);
  endfunction

  initial begin
    for (int i = 0; i < NP; i++) begin m_live[i] = 0; m_mask[i] = '0; end
    void'($urandom(32'd1207));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 free_pages", int'(free_pages), NP);
    chk("R1 tx_head_valid", int'(tx_head_valid), 0);
    chk("R1 done_head_valid", int'(done_head_valid), 0);
    chk("R1 cmd_ready", int'(cmd_ready), 1);
    chk("R1 resp_done", int'(resp_done), 0);
    chk("R1 rx_done", int'(rx_done), 0);

    // R12 nop and unassigned opcodes
    host_cmd(0, 0, 0, "R12 nop");
    host_cmd(6, 512, 3, "R12 op6");
    host_cmd(7, 512, 3, "R12 op7");

    // R3 boundary sizes
    host_cmd(1, 0, 0, "R3 zero bytes");
    host_cmd(1, 9000, 0, "R3 too large");
    host_cmd(1, 257, 0, "R3 two pages");
    host_cmd(1, 8192 - 512, 0, "R3 exact fill");
    host_cmd(1, 1, 0, "R3 pool empty");

    // R11 fragmented pool
    host_cmd(2, 0, 0, "R8 reset all");
    host_cmd(1, 256, 0, "R11 a0");
    host_cmd(1, 256, 0, "R11 a1");
    host_cmd(1, 256, 0, "R11 a2");
    host_cmd(3, 0, 1, "R5 release middle");
    host_cmd(1, 512, 0, "R11 split alloc");
    host_cmd(3, 0, 9, "R5 release unallocated");

    // R4 receive reserve
    host_cmd(2, 0, 0, "R8 reset all");
    rx_req(28 * 256, 4, "R4 down to reserve");
    rx_req(1, 4, "R4 below reserve");
    host_cmd(1, 256, 0, "R4 host ignores reserve");
    rx_req(0, 0, "R4 zero bytes");

    // R6/R7 queues with and without auto-release
    host_cmd(2, 0, 0, "R8 reset all");
    host_cmd(1, 300, 0, "R6 alloc");
    host_cmd(1, 300, 0, "R6 alloc");
    host_cmd(4, 0, 1, "R6 enqueue 1");
    host_cmd(4, 0, 0, "R6 enqueue 0");
    host_cmd(4, 0, 7, "R6 enqueue unallocated");
    auto_release = 1'b0;
    txc_evt("R7 completion to done queue");
    host_cmd(3, 0, 1, "R5 release done head");
    auto_release = 1'b1;
    txc_evt("R7 auto release");
    txc_evt("R7 empty queue");
    auto_release = 1'b0;

    // R9 transmit queue reset keeps allocations
    host_cmd(1, 700, 0, "R9 alloc");
    host_cmd(4, 0, 0, "R9 enqueue");
    host_cmd(4, 0, 0, "R9 enqueue again");
    txc_evt("R9 fill done queue");
    host_cmd(5, 0, 0, "R9 txq reset");

    // R2 command held while busy is not executed
    @(negedge clk);
    cmd_op = 3'd0; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 3'd1; cmd_bytes = 14'd256;
    chk("R2 ready low while busy", int'(cmd_ready), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 nop done", int'(resp_done), 1);
    chk("R2 nop fail", int'(resp_fail), 0);
    repeat (3) begin
      @(negedge clk);
      chk("R2 held command not run", int'(resp_done), 0);
    end
    chk("R2 free unchanged", int'(free_pages), f_cnt(m_free));

    // R10 priority with all three requesters valid
    host_cmd(2, 0, 0, "R8 reset all");
    @(negedge clk);
    cmd_op = 3'd0; cmd_valid = 1'b1;
    rx_bytes = 14'd300; rx_reserve = 6'd0; rx_valid = 1'b1;
    txc_valid = 1'b1;
    #1;
    chk("R10 host ready", int'(cmd_ready), 1);
    chk("R10 rx blocked", int'(rx_ready), 0);
    chk("R10 txc blocked", int'(txc_ready), 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    #1;
    chk("R10 busy rx", int'(rx_ready), 0);
    @(negedge clk);
    chk("R10 host done", int'(resp_done), 1);
    chk("R10 rx next", int'(rx_ready), 1);
    chk("R10 txc waits", int'(txc_ready), 0);
    @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk);
    begin
      bit ef;
      int ep;
      m_alloc(300, 0, 1, ef, ep);
      chk("R10 rx served", int'(rx_done), 1);
      chk("R10 rx pkt", int'(rx_pkt), ep);
    end
    #1;
    chk("R10 txc last", int'(txc_ready), 1);
    @(negedge clk);
    txc_valid = 1'b0;
    @(negedge clk);
    m_txc();
    check_state("R10 after completion");

    // Random mix
    for (int it = 0; it < 400; it++) begin
      int sel = int'($urandom % 16);
      int p = ($urandom % 4 != 0) ? pick_live(int'($urandom % NP)) : int'($urandom % NP);
      if ($urandom % 8 == 0) auto_release = ~auto_release;
      if (sel < 4)       host_cmd(1, rnd_bytes(), 0, "R3 random alloc");
      else if (sel < 6)  rx_req(rnd_bytes(), int'($urandom % 9), "R4 random rx");
      else if (sel < 8)  host_cmd(3, 0, p, "R5 random release");
      else if (sel < 11) host_cmd(4, 0, p, "R6 random enqueue");
      else if (sel < 13) txc_evt("R7 random completion");
      else if (sel == 13) host_cmd(5, 0, 0, "R9 random txq reset");
      else if (sel == 14) host_cmd(int'($urandom % 2) * 6, 0, 0, "R12 random nop");
      else if ($urandom % 4 == 0) host_cmd(2, 0, 0, "R8 random reset");
      else host_cmd(1, 256 * (1 + int'($urandom % 4)), 0, "R11 random pages");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule